// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block decides, every cycle, how a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) deals with read-after-write dependences. It looks at the register fields of the instruction in decode, the destination fields of the instructions in execute and memory, and flags marking loads and branches. From these it produces one stall signal, operand bypass selects for the execute stage, and bypass selects for the branch comparator in decode. The datapath, the register file and the memories sit outside the block.

Branches are resolved in decode, so their compare operands must be ready one stage earlier than ALU operands. That adds interlocks in decode beyond the usual load-use case. A mode pin turns forwarding off. The pipeline then relies only on stalls, and each dependent instruction waits in decode until its producer reaches writeback. The register file writes in the first half of a cycle and reads in the second, so a producer in writeback never needs a stall or a bypass, and the block has no writeback-stage inputs.

The execute-stage selects are worked out while the consumer is still in decode and are registered on the edge that moves it into execute. This takes the register compares off the execute-stage path. There is no other stall source, so the pipeline advances on every cycle in which `stall` is low. When `stall` is high, the surrounding logic holds the PC and the fetch/decode register and loads a bubble with all write-enables cleared into execute. The control pins are plain levels with no handshake.

Top module: `hzd_ctrl`

## Requirements
- R1: An execute-stage select reads 2'b10 (take the execute/memory register) in the cycle a consumer sits in execute, when the instruction directly ahead of it, a non-load, writes that source with forwarding on.
- R2: The select reads 2'b01 (take the memory/writeback register) when the nearest writer of that source is two instructions ahead. This includes loads.
- R3: With the nearest writer three instructions ahead, there is no stall and the select reads 2'b00 (register file value).
- R4: With forwarding on, a load followed directly by a non-branch consumer of its destination raises `stall` for exactly one cycle.
- R5: With `fwd_enable` low, `stall` stays high while any used decode source is written by a valid instruction in execute or memory. The execute selects are registered as 2'b00.
- R6: A branch in decode stalls one cycle behind an ALU writer in execute and two cycles behind a load writer in execute, and it stalls behind a load in memory. While a non-load writer of a branch source is in memory (and none is in execute), `id_br_fwd_a`/`id_br_fwd_b` is 1.
- R7: Register 0, an unused source, an invalid stage and a clear write-enable never produce a dependence.
- R8: When both the execute-stage and the memory-stage instruction write the same source, the younger one wins and the select is 2'b10.
- R9: In the cycle after a stall, both execute selects are 2'b00, because a bubble occupies execute.
- R10: While reset is asserted, both execute selects are 2'b00.
- R11: End-to-end cycle counts match hand-worked schedules. A five-instruction chain on one register takes 9 cycles with forwarding and 11 without. A load followed by three dependents takes 9 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_enable | input | 1 | 1 = bypassing on, 0 = stall-only operation |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | AW | First source register in decode |
| id_rs2 | input | AW | Second source register in decode |
| id_rs1_used | input | 1 | First source is read |
| id_rs2_used | input | 1 | Second source is read |
| id_branch | input | 1 | Decode instruction is a branch compared in decode |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_rd | input | AW | Destination register in execute |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_rd | input | AW | Destination register in memory |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_load | input | 1 | Memory instruction is a load |
| stall | output | 1 | Hold PC and fetch/decode register, inject bubble into execute |
| ex_fwd_a | output | 2 | First execute operand select: 00 file, 01 mem/wb, 10 ex/mem |
| ex_fwd_b | output | 2 | Second execute operand select, same encoding |
| id_br_fwd_a | output | 1 | First branch operand taken from the execute/memory register |
| id_br_fwd_b | output | 1 | Second branch operand taken from the execute/memory register |

## Verification
`stall` and the two branch bypass selects depend only on the current inputs. They are due in the same cycle that the decode and older stage fields are presented. The execute selects are due one clock later, in the cycle the consumer occupies execute. The bench drives stage fields just after a falling edge and samples the outputs one nanosecond later. It compares stall and branch selects against what its reference model derives from the current stage contents, and it compares the execute selects against the value its model stored when it moved that instruction into execute on the previous edge. Whole-program cycle totals and stall counts are then checked against hand-derived schedules.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;

  typedef struct packed {
    logic hit;
    logic load;
  } prod_hit_t;

endpackage

// File: rtl/hzd_src_match.sv
`timescale 1ns/1ps
module hzd_src_match
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          used,
  input  logic          prod_valid,
  input  logic          prod_wen,
  input  logic          prod_load,
  input  logic [AW-1:0] prod_rd,
  output prod_hit_t     hit
);
  logic nonzero;

  always_comb begin
    nonzero  = |src;
    hit.hit  = used && nonzero && prod_valid && prod_wen && (src == prod_rd);
    hit.load = hit.hit && prod_load;
  end
endmodule

// File: rtl/hzd_src_eval.sv
`timescale 1ns/1ps
module hzd_src_eval
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          used,
  input  logic          is_branch,
  input  logic          ex_valid,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  output logic          stall_fwd,
  output logic          stall_nofwd,
  output logic          br_bypass,
  output logic [1:0]    next_sel
);
  prod_hit_t near_h;
  prod_hit_t far_h;
  fwd_sel_e  sel_e;

  hzd_src_match #(.AW(AW)) u_near (
    .src(src), .used(used),
    .prod_valid(ex_valid), .prod_wen(ex_wen), .prod_load(ex_load), .prod_rd(ex_rd),
    .hit(near_h)
  );

  hzd_src_match #(.AW(AW)) u_far (
    .src(src), .used(used),
    .prod_valid(mem_valid), .prod_wen(mem_wen), .prod_load(mem_load), .prod_rd(mem_rd),
    .hit(far_h)
  );

  always_comb begin
    stall_nofwd = near_h.hit || far_h.hit;
    if (is_branch) begin
      stall_fwd = near_h.hit || far_h.load;
    end else begin
      stall_fwd = near_h.load;
    end
    br_bypass = is_branch && far_h.hit && !far_h.load && !near_h.hit;
    if (near_h.hit) begin
      sel_e = SEL_MEM;
    end else if (far_h.hit) begin
      sel_e = SEL_WB;
    end else begin
      sel_e = SEL_RF;
    end
    next_sel = sel_e;
  end
endmodule

// File: rtl/hzd_sel_pipe.sv
`timescale 1ns/1ps
module hzd_sel_pipe #(
  parameter int NSRC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_next,
  input  logic [NSRC-1:0][1:0] next_sel,
  output logic [NSRC-1:0][1:0] sel_q
);
  for (genvar g = 0; g < NSRC; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[g] <= 2'b00;
      end else if (load_next) begin
        sel_q[g] <= next_sel[g];
      end else begin
        sel_q[g] <= 2'b00;
      end
    end
  end
endmodule

// File: rtl/hzd_ctrl.sv
`timescale 1ns/1ps
module hzd_ctrl #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_enable,
  input  logic          id_valid,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_rs1_used,
  input  logic          id_rs2_used,
  input  logic          id_branch,
  input  logic          ex_valid,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  output logic          stall,
  output logic [1:0]    ex_fwd_a,
  output logic [1:0]    ex_fwd_b,
  output logic          id_br_fwd_a,
  output logic          id_br_fwd_b
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] src;
  logic [NSRC-1:0]         used;
  logic [NSRC-1:0]         st_fwd;
  logic [NSRC-1:0]         st_nofwd;
  logic [NSRC-1:0]         byp;
  logic [NSRC-1:0][1:0]    nxt;
  logic [NSRC-1:0][1:0]    selq;

  assign src  = {id_rs2, id_rs1};
  assign used = {id_rs2_used, id_rs1_used} & {NSRC{id_valid}};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hzd_src_eval #(.AW(AW)) u_eval (
      .src(src[g]), .used(used[g]), .is_branch(id_branch),
      .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
      .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load),
      .stall_fwd(st_fwd[g]), .stall_nofwd(st_nofwd[g]),
      .br_bypass(byp[g]), .next_sel(nxt[g])
    );
  end

  assign stall       = fwd_enable ? (|st_fwd) : (|st_nofwd);
  assign id_br_fwd_a = fwd_enable & byp[0];
  assign id_br_fwd_b = fwd_enable & byp[1];

  hzd_sel_pipe #(.NSRC(NSRC)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .load_next(fwd_enable && !stall),
    .next_sel(nxt), .sel_q(selq)
  );

  assign ex_fwd_a = selq[0];
  assign ex_fwd_b = selq[1];
endmodule

// File: rtl/hzd_ctrl_chk.sv
`timescale 1ns/1ps
module hzd_ctrl_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fwd_enable,
  input logic          id_valid,
  input logic [AW-1:0] id_rs1,
  input logic [AW-1:0] id_rs2,
  input logic          id_rs1_used,
  input logic          id_rs2_used,
  input logic          id_branch,
  input logic          ex_valid,
  input logic [AW-1:0] ex_rd,
  input logic          ex_wen,
  input logic          ex_load,
  input logic          mem_valid,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wen,
  input logic          mem_load,
  input logic          stall,
  input logic [1:0]    ex_fwd_a,
  input logic [1:0]    ex_fwd_b,
  input logic          id_br_fwd_a,
  input logic          id_br_fwd_b
);
  logic ex_w1, mem_w1;
  assign ex_w1  = id_valid && id_rs1_used && id_rs1 != '0 && ex_valid && ex_wen && ex_rd == id_rs1;
  assign mem_w1 = id_valid && id_rs1_used && id_rs1 != '0 && mem_valid && mem_wen && mem_rd == id_rs1;

  assert_load_use_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_enable && !id_branch && ex_w1 && ex_load) |-> stall);

  assert_nofwd_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwd_enable && (ex_w1 || mem_w1)) |-> stall);

  assert_nofwd_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_enable |=> (ex_fwd_a == 2'b00 && ex_fwd_b == 2'b00));

  assert_branch_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_enable && id_branch && ex_w1) |-> stall);

  assert_zero_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((!id_rs1_used || id_rs1 == '0) && (!id_rs2_used || id_rs2 == '0))
      |-> (!stall && !id_br_fwd_a && !id_br_fwd_b));

  assert_younger_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_enable && !stall && ex_w1 && mem_w1) |=> ex_fwd_a == 2'b10);

  assert_bubble_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (ex_fwd_a == 2'b00 && ex_fwd_b == 2'b00));
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.AW(AW)) chk_i (.*);

// File: tb/hzd_ctrl_tb_top.sv
`timescale 1ns/1ps
module hzd_ctrl_tb_top;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwd_enable, id_valid, id_rs1_used, id_rs2_used, id_branch;
  logic [AW-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
  logic ex_valid, ex_wen, ex_load, mem_valid, mem_wen, mem_load;
  logic stall, id_br_fwd_a, id_br_fwd_b;
  logic [1:0] ex_fwd_a, ex_fwd_b;

  always #2 clk = ~clk;

  hzd_ctrl #(.AW(AW)) dut_i (.*);

  typedef struct {
    int idx; bit v; int rd; int rs1; int rs2;
    bit u1; bit u2; bit we; bit ld; bit br;
  } ins_t;

  ins_t  prog[$];
  ins_t  id_s, ex_s, mem_s, wb_s, bub;
  int    checks = 0, failures = 0;
  bit    fwd = 1'b1;
  int    exp_a, exp_b;
  string tag_a, tag_b, ptag;

  task automatic chk(input bit ok, input string tg, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s (%s) actual=%0d expected=%0d", tg, what, ptag, act, exp);
    end
  endtask

  task automatic add(input int rd, input int rs1, input int rs2, input bit u1, input bit u2,
                     input bit we, input bit ld, input bit br);
    ins_t t;
    t.idx = prog.size(); t.v = 1'b1; t.rd = rd; t.rs1 = rs1; t.rs2 = rs2;
    t.u1 = u1; t.u2 = u2; t.we = we; t.ld = ld; t.br = br;
    prog.push_back(t);
  endtask

  task automatic alu(input int rd, input int a, input int b); add(rd, a, b, 1, 1, 1, 0, 0); endtask
  task automatic lod(input int rd, input int base);           add(rd, base, 0, 1, 0, 1, 1, 0); endtask
  task automatic bnz(input int r);                           add(0, r, 0, 1, 0, 0, 0, 1); endtask

  // nearest older writer: 1 = execute, 2 = memory, 0 = none
  function automatic int writer_at(input int s);
    if (s == 0) return 0;
    if (ex_s.v && ex_s.we && ex_s.rd == s) return 1;
    if (mem_s.v && mem_s.we && mem_s.rd == s) return 2;
    return 0;
  endfunction

  function automatic bit src_stall(input int s, input bit u);
    int d;
    if (!u || !id_s.v) return 1'b0;
    d = writer_at(s);
    if (!fwd) return d != 0;
    if (id_s.br) return (d == 1) || (d == 2 && mem_s.ld);
    return d == 1 && ex_s.ld;
  endfunction

  function automatic bit src_byp(input int s, input bit u);
    return fwd && u && id_s.v && id_s.br && writer_at(s) == 2 && !mem_s.ld;
  endfunction

  task automatic sel_for(input int s, input bit u, output int sel, output string tg);
    int d;
    d = (u && id_s.v) ? writer_at(s) : 0;
    sel = 0; tg = "R3";
    if (!fwd) begin sel = 0; tg = "R5"; end
    else if (d == 1) begin
      sel = 2;
      tg = (mem_s.v && mem_s.we && mem_s.rd == s) ? "R8" : "R1";
    end else if (d == 2) begin sel = 1; tg = "R2"; end
  endtask

  task automatic drive();
    fwd_enable  = fwd;
    id_valid    = id_s.v;  id_rs1 = AW'(id_s.rs1); id_rs2 = AW'(id_s.rs2);
    id_rs1_used = id_s.u1; id_rs2_used = id_s.u2;  id_branch = id_s.br;
    ex_valid    = ex_s.v;  ex_rd = AW'(ex_s.rd);   ex_wen = ex_s.we;  ex_load = ex_s.ld;
    mem_valid   = mem_s.v; mem_rd = AW'(mem_s.rd); mem_wen = mem_s.we; mem_load = mem_s.ld;
  endtask

  task automatic run_prog(input string t, input bit f, input int exp_total, input int exp_stalls);
    int pc, cyc, nst, n, total;
    bit st;
    string stag;
    ptag = t; fwd = f; n = prog.size();
    id_s = bub; ex_s = bub; mem_s = bub; wb_s = bub;
    pc = 0; cyc = 1; nst = 0; total = -1;
    exp_a = 0; exp_b = 0; tag_a = "R9"; tag_b = "R9";
    while (cyc < 200) begin
      @(negedge clk);
      drive();
      #1;
      st   = src_stall(id_s.rs1, id_s.u1) || src_stall(id_s.rs2, id_s.u2);
      stag = !fwd ? "R5" : (id_s.br ? "R6" : "R4");
      chk(stall == st, stag, "stall", int'(stall), int'(st));
      chk(id_br_fwd_a == src_byp(id_s.rs1, id_s.u1), "R6", "branch bypass a",
          int'(id_br_fwd_a), int'(src_byp(id_s.rs1, id_s.u1)));
      chk(id_br_fwd_b == src_byp(id_s.rs2, id_s.u2), "R6", "branch bypass b",
          int'(id_br_fwd_b), int'(src_byp(id_s.rs2, id_s.u2)));
      chk(int'(ex_fwd_a) == exp_a, tag_a, "ex select a", int'(ex_fwd_a), exp_a);
      chk(int'(ex_fwd_b) == exp_b, tag_b, "ex select b", int'(ex_fwd_b), exp_b);
      if (wb_s.v && wb_s.idx == n - 1) begin
        total = cyc;
        break;
      end
      if (st) begin
        nst++;
        exp_a = 0; exp_b = 0; tag_a = "R9"; tag_b = "R9";
        wb_s = mem_s; mem_s = ex_s; ex_s = bub;
      end else begin
        sel_for(id_s.rs1, id_s.u1, exp_a, tag_a);
        sel_for(id_s.rs2, id_s.u2, exp_b, tag_b);
        wb_s = mem_s; mem_s = ex_s; ex_s = id_s;
        id_s = (pc < n) ? prog[pc] : bub;
        pc++;
      end
      cyc++;
    end
    chk(total == exp_total, "R11", "total cycles", total, exp_total);
    chk(nst == exp_stalls, "R11", "stall cycles", nst, exp_stalls);
    prog.delete();
  endtask

  task automatic chain5();  alu(1,3,3); alu(4,1,5); alu(6,1,7); alu(8,1,9); alu(10,1,11); endtask
  task automatic ldchain(); lod(1,2); alu(4,1,5); alu(6,1,7); alu(8,1,9); endtask

  initial begin
    bub.v = 1'b0;
    id_s = bub; ex_s = bub; mem_s = bub; wb_s = bub;
    fwd = 1'b1; ptag = "reset";
    drive();
    repeat (3) @(negedge clk);
    #1;
    chk(ex_fwd_a == 2'b00, "R10", "reset select a", int'(ex_fwd_a), 0);
    chk(ex_fwd_b == 2'b00, "R10", "reset select b", int'(ex_fwd_b), 0);
    chk(stall == 1'b0, "R10", "reset stall", int'(stall), 0);
    @(negedge clk); rst_n = 1'b1;

    chain5();  run_prog("chain fwd R1 R2 R3", 1, 9, 0);
    chain5();  run_prog("chain nofwd R5", 0, 11, 2);
    ldchain(); run_prog("load-use fwd R4", 1, 9, 1);
    ldchain(); run_prog("load-use nofwd R5", 0, 10, 2);
    alu(4,2,3); bnz(4); run_prog("branch after alu R6", 1, 7, 1);
    alu(4,2,3); bnz(4); run_prog("branch after alu nofwd R6", 0, 8, 2);
    lod(6,2); bnz(6);   run_prog("branch after load R6", 1, 8, 2);
    alu(4,2,3); alu(8,9,9); bnz(4); run_prog("branch two behind R6", 1, 7, 0);
    alu(4,2,3); alu(8,9,9); bnz(4); run_prog("branch two behind nofwd R6", 0, 8, 1);
    alu(2,1,1); alu(2,2,5); alu(7,2,2); run_prog("priority R8", 1, 7, 0);
    alu(2,1,1); alu(2,2,5); alu(7,2,2); run_prog("priority nofwd R8", 0, 11, 4);
    alu(1,3,3); alu(8,9,9); alu(9,8,8); alu(4,1,1); run_prog("distance three R3", 1, 8, 0);
    alu(1,3,3); alu(8,9,9); alu(12,9,9); alu(4,1,1); run_prog("distance three nofwd R3", 0, 8, 0);
    alu(0,1,1); alu(3,0,0); add(5,1,1,1,1,0,0,0); alu(6,5,5); lod(0,2); alu(7,0,0); bnz(0);
    run_prog("zero and no-write R7", 1, 11, 0);
    alu(0,1,1); alu(3,0,0); add(5,1,1,1,1,0,0,0); alu(6,5,5); lod(0,2); alu(7,0,0); bnz(0);
    run_prog("zero and no-write nofwd R7", 0, 11, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired (R11) actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule